// File: doc/BRIEF.md
# CEC Received-Bit Timing Error Checker

This block watches the receive line of a single-wire consumer-electronics-control bus and judges the timing of every data bit. A falling edge of the resynchronised line opens a bit. From that point a counter advances on each pulse of the slow sampling tick `fs_tick`, which is about 32.768 kHz and arrives as a one-cycle enable in the system clock domain. When the line rises again the count is compared against four thresholds. They split the bit period into an early zone, a logical-1 window, a forbidden middle zone, a logical-0 window and a late zone.

Each threshold has a base value and a 3-bit trim that moves it one tick per step. The early-1 limit is 13 minus trim. The gap opens after 26 plus trim and closes at 43 minus trim. The late-0 limit is 56 plus trim. With the extended check enabled, a rise in the early zone or the middle zone is an error. A line that is still low when the late-0 limit has passed is also an error. After any error the checker ignores the line until the next falling edge. With the extended check disabled the block raises no error and splits 1 from 0 at tick 35. Software must clear the receive enable and let reception stop before it changes the trims.

Top module: `cec_bit_timing_checker`

## Requirements
- R1: After reset `err_pulse`, `bit_valid` and `bit_val` are 0.
- R2: With `wave_chk_en`=1, a rise at a tick count c below 13 - `trim_early1` gives one `err_pulse` and no `bit_valid`.
- R3: With `wave_chk_en`=1, a rise at 13 - `trim_early1` <= c <= 26 + `trim_gap_lo` gives `bit_valid`=1 with `bit_val`=1. `err_pulse` and `bit_valid` are never high together.
- R4: With `wave_chk_en`=1, a rise at 26 + `trim_gap_lo` < c < 43 - `trim_gap_hi` gives one `err_pulse`.
- R5: With `wave_chk_en`=1, a rise at 43 - `trim_gap_hi` <= c <= 56 + `trim_late0` gives `bit_valid`=1 with `bit_val`=0.
- R6: With `wave_chk_en`=1, if the line is still low when tick number 57 + `trim_late0` arrives, `err_pulse` fires once on that tick. The rise that follows produces no output.
- R7: With `wave_chk_en`=0 no `err_pulse` is raised. A rise gives `bit_valid` with `bit_val`=1 when c < 35, else 0.
- R8: While `rx_en`=0 no `err_pulse` or `bit_valid` is produced on the following cycle, and no bit is measured.
- R9: The result of a rise appears on the third rising clock edge after `line_in` goes high. `err_pulse` and `bit_valid` last one cycle.
- R10: The tick counter saturates at its maximum (127) instead of wrapping. With `wave_chk_en`=0, a low time of 140 ticks decodes as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fs_tick | input | 1 | One-cycle sampling tick enable |
| rx_en | input | 1 | Receive enable |
| wave_chk_en | input | 1 | Enables the trimmed error checks |
| line_in | input | 1 | Asynchronous bus receive line |
| trim_early1 | input | 3 | Early-1 limit reduction, ticks |
| trim_gap_lo | input | 3 | Gap start extension, ticks |
| trim_gap_hi | input | 3 | Gap end reduction, ticks |
| trim_late0 | input | 3 | Late-0 limit extension, ticks |
| err_pulse | output | 1 | One-cycle waveform error |
| bit_valid | output | 1 | One-cycle strobe for a decoded bit |
| bit_val | output | 1 | Decoded bit value, valid with `bit_valid` |

## Verification
A falling edge on `line_in` opens the bit after three clock edges: two synchroniser stages and the state register. The bench therefore waits three cycles before it issues any tick. A rising edge yields its result on the third clock edge. The bench samples the outputs on the falling clock edge right after that point, and it also checks that nothing appeared one cycle earlier. A late-limit error falls on the clock edge that takes the offending tick. That error is caught by a pulse monitor sampling on every falling edge. Each trial is judged by the difference in pulse counts, so a second or stray pulse is also seen.

// File: rtl/cec_chk_pkg.sv
package cec_chk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEAS = 2'd1,
        ST_WAIT = 2'd2
    } chk_state_e;

    typedef struct packed {
        logic rise_err;
        logic rise_bit;
        logic late_hit;
    } verdict_t;

endpackage

// File: rtl/cec_line_sync.sv
module cec_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[STAGES-2:0], line_in};
        s_d.prev = s_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{sh: '1, prev: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign line_s = s_q.sh[STAGES-1];
    assign rise   = line_s & ~s_q.prev;
    assign fall   = ~line_s & s_q.prev;
endmodule

// File: rtl/cec_tick_counter.sv
module cec_tick_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (run && tick && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/cec_window_eval.sv
module cec_window_eval
    import cec_chk_pkg::*;
#(
    parameter int CNT_W       = 7,
    parameter int TRIM_W      = 3,
    parameter int EARLY1_BASE = 13,
    parameter int GAP_LO_BASE = 26,
    parameter int GAP_HI_BASE = 43,
    parameter int LATE0_BASE  = 56,
    parameter int PLAIN_SPLIT = 35
) (
    input  logic [CNT_W-1:0]  cnt,
    input  logic              chk_en,
    input  logic [TRIM_W-1:0] trim_early1,
    input  logic [TRIM_W-1:0] trim_gap_lo,
    input  logic [TRIM_W-1:0] trim_gap_hi,
    input  logic [TRIM_W-1:0] trim_late0,
    output verdict_t          verdict
);
    localparam logic [CNT_W-1:0] E1_B  = CNT_W'(EARLY1_BASE);
    localparam logic [CNT_W-1:0] GL_B  = CNT_W'(GAP_LO_BASE);
    localparam logic [CNT_W-1:0] GH_B  = CNT_W'(GAP_HI_BASE);
    localparam logic [CNT_W-1:0] L0_B  = CNT_W'(LATE0_BASE);
    localparam logic [CNT_W-1:0] SPLIT = CNT_W'(PLAIN_SPLIT);

    logic [CNT_W-1:0] early_lim, gap_lo, gap_hi, late_lim;
    logic below_early, in_one, in_gap, past_late;

    always_comb begin
        early_lim   = E1_B - CNT_W'(trim_early1);
        gap_lo      = GL_B + CNT_W'(trim_gap_lo);
        gap_hi      = GH_B - CNT_W'(trim_gap_hi);
        late_lim    = L0_B + CNT_W'(trim_late0);

        below_early = (cnt < early_lim);
        in_one      = !below_early && (cnt <= gap_lo);
        in_gap      = (cnt > gap_lo) && (cnt < gap_hi);
        past_late   = (cnt > late_lim);

        if (chk_en) begin
            verdict.rise_err = below_early | in_gap | past_late;
            verdict.rise_bit = in_one;
            verdict.late_hit = (cnt >= late_lim);
        end else begin
            verdict.rise_err = 1'b0;
            verdict.rise_bit = (cnt < SPLIT);
            verdict.late_hit = 1'b0;
        end
    end
endmodule

// File: rtl/cec_bit_timing_checker.sv
module cec_bit_timing_checker
    import cec_chk_pkg::*;
#(
    parameter int CNT_W       = 7,
    parameter int TRIM_W      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int EARLY1_BASE = 13,
    parameter int GAP_LO_BASE = 26,
    parameter int GAP_HI_BASE = 43,
    parameter int LATE0_BASE  = 56,
    parameter int PLAIN_SPLIT = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_tick,
    input  logic              rx_en,
    input  logic              wave_chk_en,
    input  logic              line_in,
    input  logic [TRIM_W-1:0] trim_early1,
    input  logic [TRIM_W-1:0] trim_gap_lo,
    input  logic [TRIM_W-1:0] trim_gap_hi,
    input  logic [TRIM_W-1:0] trim_late0,
    output logic              err_pulse,
    output logic              bit_valid,
    output logic              bit_val
);
    typedef struct packed {
        chk_state_e st;
        logic       err;
        logic       vld;
        logic       bitv;
    } ctl_t;

    logic             line_s, line_rise, line_fall;
    logic [CNT_W-1:0] tick_cnt;
    logic             cnt_clr, cnt_run;
    verdict_t         verdict;
    ctl_t             c_d, c_q;

    cec_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .line_s  (line_s),
        .rise    (line_rise),
        .fall    (line_fall)
    );

    assign cnt_clr = rx_en && line_fall;
    assign cnt_run = rx_en && (c_q.st == ST_MEAS) && !line_s;

    cec_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .run   (cnt_run),
        .tick  (fs_tick),
        .cnt   (tick_cnt)
    );

    cec_window_eval #(
        .CNT_W       (CNT_W),
        .TRIM_W      (TRIM_W),
        .EARLY1_BASE (EARLY1_BASE),
        .GAP_LO_BASE (GAP_LO_BASE),
        .GAP_HI_BASE (GAP_HI_BASE),
        .LATE0_BASE  (LATE0_BASE),
        .PLAIN_SPLIT (PLAIN_SPLIT)
    ) u_eval (
        .cnt         (tick_cnt),
        .chk_en      (wave_chk_en),
        .trim_early1 (trim_early1),
        .trim_gap_lo (trim_gap_lo),
        .trim_gap_hi (trim_gap_hi),
        .trim_late0  (trim_late0),
        .verdict     (verdict)
    );

    always_comb begin
        c_d      = c_q;
        c_d.err  = 1'b0;
        c_d.vld  = 1'b0;
        if (!rx_en) begin
            c_d.st = ST_IDLE;
        end else begin
            unique case (c_q.st)
                ST_IDLE, ST_WAIT: begin
                    if (line_fall) begin
                        c_d.st = ST_MEAS;
                    end
                end
                ST_MEAS: begin
                    if (line_rise) begin
                        c_d.err  = verdict.rise_err;
                        c_d.vld  = !verdict.rise_err;
                        c_d.bitv = verdict.rise_bit;
                        c_d.st   = ST_IDLE;
                    end else if (verdict.late_hit && fs_tick && !line_s) begin
                        c_d.err  = 1'b1;
                        c_d.st   = ST_WAIT;
                    end
                end
                default: c_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, err: 1'b0, vld: 1'b0, bitv: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign err_pulse = c_q.err;
    assign bit_valid = c_q.vld;
    assign bit_val   = c_q.bitv;
endmodule

// File: rtl/cec_bit_timing_sva.sv
module cec_bit_timing_sva #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic             wave_chk_en,
    input logic             err_pulse,
    input logic             bit_valid,
    input logic [CNT_W-1:0] tick_cnt
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    // R3: an error and a decoded bit never coincide
    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_pulse && bit_valid));

    // R7: no error when the extended check is off
    p_quiet_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wave_chk_en |=> !err_pulse);

    // R8: receive disabled yields nothing on the next cycle
    p_rx_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!err_pulse && !bit_valid));

    // R9: error pulse lasts one cycle
    p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);

    // R9: valid strobe lasts one cycle
    p_vld_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    // R10: counter holds at its top or restarts, never wraps upward
    p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_cnt == CNT_TOP) |=> (tick_cnt == CNT_TOP || tick_cnt == '0));
endmodule

bind cec_bit_timing_checker cec_bit_timing_sva #(.CNT_W(CNT_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en       (rx_en),
    .wave_chk_en (wave_chk_en),
    .err_pulse   (err_pulse),
    .bit_valid   (bit_valid),
    .tick_cnt    (tick_cnt)
);

// File: tb/cec_bit_timing_checker_tb.sv
`timescale 1ns/1ps
module cec_bit_timing_checker_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fs_tick = 1'b0;
    logic       rx_en = 1'b0;
    logic       wave_chk_en = 1'b0;
    logic       line_in = 1'b1;
    logic [2:0] trim_early1 = '0, trim_gap_lo = '0, trim_gap_hi = '0, trim_late0 = '0;
    logic       err_pulse, bit_valid, bit_val;

    int n_checks = 0;
    int n_fail = 0;
    int mon_err = 0;
    int mon_vld = 0;
    logic mon_bit = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cec_bit_timing_checker u_dut (
        .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .rx_en(rx_en),
        .wave_chk_en(wave_chk_en), .line_in(line_in),
        .trim_early1(trim_early1), .trim_gap_lo(trim_gap_lo),
        .trim_gap_hi(trim_gap_hi), .trim_late0(trim_late0),
        .err_pulse(err_pulse), .bit_valid(bit_valid), .bit_val(bit_val)
    );

    always @(negedge clk) begin
        if (err_pulse) mon_err <= mon_err + 1;
        if (bit_valid) begin
            mon_vld <= mon_vld + 1;
            mon_bit <= bit_val;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // expected outcome: 0 = bit 0, 1 = bit 1, 2 = rise error, 3 = late error
    function automatic int model(input int c, input bit en, input int te, input int tl,
                                 input int th, input int t0);
        if (!en) return (c < 35) ? 1 : 0;
        if (c > 56 + t0) return 3;
        if (c < 13 - te) return 2;
        if (c <= 26 + tl) return 1;
        if (c < 43 - th) return 2;
        return 0;
    endfunction

    function automatic string req_of(input int c, input int kind, input bit en, input int te);
        if (!en) return (c > 126) ? "R10" : "R7";
        case (kind)
            0: return "R5";
            1: return "R3";
            3: return "R6";
            default: return (c < 13 - te) ? "R2" : "R4";
        endcase
    endfunction

    // one bit with n ticks of low time; result compared with model
    task automatic run_bit(input int n, input int kind, input string req);
        int e0, v0;
        bit any_out;
        e0 = mon_err; v0 = mon_vld;
        line_in = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            fs_tick = 1'b1;
            @(negedge clk);
            fs_tick = 1'b0;
        end
        line_in = 1'b1;
        repeat (2) @(negedge clk);
        any_out = err_pulse | bit_valid;
        @(negedge clk);
        if (kind == 0 || kind == 1 || kind == 2) begin
            check(!any_out && (err_pulse == (kind == 2)) && (bit_valid == (kind != 2)),
                  "R9", {err_pulse, bit_valid, any_out}, (kind == 2) ? 4 : 2);
        end
        repeat (3) @(negedge clk);
        if (kind == 4) begin
            check(mon_err == e0 && mon_vld == v0, req, (mon_err - e0) * 10 + (mon_vld - v0), 0);
        end else if (kind >= 2) begin
            check(mon_err - e0 == 1 && mon_vld == v0, req,
                  (mon_err - e0) * 10 + (mon_vld - v0), 10);
        end else begin
            check(mon_err == e0 && mon_vld - v0 == 1 && mon_bit == kind[0], req,
                  (mon_err - e0) * 100 + (mon_vld - v0) * 10 + int'(mon_bit), 10 + kind);
        end
    endtask

    initial begin
        int cfg [5][4] = '{'{0,0,0,0}, '{7,7,7,7}, '{3,5,2,6}, '{1,0,4,7}, '{6,2,7,1}};
        repeat (3) @(negedge clk);
        // R1: reset state
        check(err_pulse == 0 && bit_valid == 0 && bit_val == 0, "R1",
              {err_pulse, bit_valid, bit_val}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R8: disabled reception produces nothing
        rx_en = 1'b0; wave_chk_en = 1'b1;
        run_bit(20, 4, "R8");
        run_bit(5, 4, "R8");

        rx_en = 1'b1;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            trim_early1 = cfg[k][0][2:0];
            trim_gap_lo = cfg[k][1][2:0];
            trim_gap_hi = cfg[k][2][2:0];
            trim_late0  = cfg[k][3][2:0];
            wave_chk_en = (k != 4);
            repeat (2) @(negedge clk);
            for (int c = 0; c <= 70; c++) begin
                int kind;
                kind = model(c, wave_chk_en, cfg[k][0], cfg[k][1], cfg[k][2], cfg[k][3]);
                run_bit(c, kind, req_of(c, kind, wave_chk_en, cfg[k][0]));
            end
        end

        // R10: saturation with plain decoding
        wave_chk_en = 1'b0;
        repeat (2) @(negedge clk);
        run_bit(140, 0, "R10");
        // R6: late error on the limit tick, at base trim 0 and max trim
        wave_chk_en = 1'b1; trim_late0 = 3'd0;
        repeat (2) @(negedge clk);
        run_bit(57, 3, "R6");
        run_bit(56, 0, "R5");
        trim_late0 = 3'd7;
        repeat (2) @(negedge clk);
        run_bit(64, 3, "R6");
        run_bit(63, 0, "R5");

        done = 1'b1;
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule